// File: doc/BRIEF.md
# Quadword Load/Store Beat Sequencer

This block lets a core with a single 32-bit memory port execute wide memory instructions. A 128-bit quadword load or store is broken into four 32-bit beats, and a 64-bit doubleword store into two. All beats share one request/wait handshake, and a beat counter selects the address and the register lane for each beat.

The core raises `start_i` for one cycle with an operation code, an effective address, a destination register index and the full source register value. The sequencer then holds `busy_o` high until it is done, and the core stalls for that whole time.

For loads, every returned word appears on a lane-write port aimed at the destination wide register. On the final beat the sequencer updates the scalar copy of the destination from lane 0 and pulses `retire_o` once. For stores, each beat carries one source lane as write data.

Top module: `qw_beat_seq`

## Requirements
- R1: After reset, `busy_o`, `mem_req_o`, `retire_o`, `wide_we_o` and `scalar_we_o` are all 0.
- R2: In idle, a `start_i` pulse with `op_i` equal to 0 (quadword load), 1 (quadword store) or 2 (doubleword store) starts a sequence, and `busy_o` is high from the next cycle through the retire cycle. `start_i` with `op_i` equal to 3 is ignored, and so is `start_i` while busy.
- R3: Each beat asserts `mem_req_o` for exactly one cycle. It then waits, for any number of cycles, until `mem_ready_i` is high. The next beat's request comes in the cycle after that response. `mem_ready_i` is ignored in the request cycle.
- R4: Beat N (counting from 0) presents `mem_addr_o` = `ea_i` + 4*N.
- R5: On the response to load beat N, `wide_we_o` is high for that cycle, with `wide_lane_o` = N, `wide_data_o` = `mem_rdata_i` and `wide_idx_o` = the destination index.
- R6: On the final load beat, `scalar_we_o` is high with `scalar_data_o` equal to the word returned on beat 0. It is never high on any other beat.
- R7: `retire_o` pulses exactly once per sequence, in the cycle of the final beat's response, and `busy_o` is low in the cycle after.
- R8: A quadword store issues four beats with `mem_we_o` = 1, carrying source lanes 0, 1, 2, 3 in that order.
- R9: A doubleword store issues exactly two beats, carrying source lanes 0 and 1.
- R10: A load to register index 0 still runs all four beats and retires, but never raises `wide_we_o` or `scalar_we_o`.
- R11: Lanes are little-endian: lane N is bits [32N+31:32N] of the wide value, so lane 0 goes to the lowest address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Issue pulse from the core |
| op_i | input | 2 | 0 quadword load, 1 quadword store, 2 doubleword store |
| ea_i | input | 32 | Effective byte address |
| idx_i | input | 5 | Destination register index (loads) |
| src_i | input | 128 | Source wide register value (stores) |
| mem_req_o | output | 1 | Beat request, one cycle per beat |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | 32 | Beat address |
| mem_wdata_o | output | 32 | Beat write data |
| mem_ready_i | input | 1 | Memory response for the pending beat |
| mem_rdata_i | input | 32 | Read data, valid with mem_ready_i |
| busy_o | output | 1 | Sequence in progress, stalls the core |
| retire_o | output | 1 | Instruction completes |
| wide_we_o | output | 1 | Wide register lane write |
| wide_idx_o | output | 5 | Wide register index |
| wide_lane_o | output | 2 | Lane being written |
| wide_data_o | output | 32 | Lane data |
| scalar_we_o | output | 1 | Scalar register write |
| scalar_data_o | output | 32 | Scalar write data (lane 0) |

## Verification
The main function is tried with a table of loads, quadword stores and doubleword stores. The table varies the addresses, register indices and source patterns, and sets memory latency to zero, one or several cycles. Distinct patterns in every source lane show whether the lanes go out in the right order and position, and address-keyed memory data shows whether each returned word lands in the right lane. Cases with early ready pulses, a zero destination index and repeated start pulses while busy show whether a sequence can be cut short or restarted, and whether register 0 is protected.

// File: rtl/qbs_pkg.sv
package qbs_pkg;
  typedef enum logic [1:0] {
    OP_LQ  = 2'd0,
    OP_SQ  = 2'd1,
    OP_SD  = 2'd2,
    OP_BAD = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } state_e;
endpackage

// File: rtl/qbs_ctrl.sv
module qbs_ctrl
  import qbs_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_ok_i,
  input  logic [BEAT_W-1:0] last_beat_i,
  input  logic              mem_ready_i,
  output state_e            state_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              accept_o,
  output logic              beat_done_o,
  output logic              final_o
);
  state_e state_q, state_d;
  logic [BEAT_W-1:0] beat_q;

  assign accept_o    = (state_q == ST_IDLE) && start_i && op_ok_i;
  assign beat_done_o = (state_q == ST_WAIT) && mem_ready_i;
  assign final_o     = beat_done_o && (beat_q == last_beat_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_o) state_d = ST_REQ;
      ST_REQ:  state_d = ST_WAIT;
      ST_WAIT: if (beat_done_o) state_d = final_o ? ST_IDLE : ST_REQ;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept_o) beat_q <= '0;
      else if (beat_done_o && !final_o) beat_q <= beat_q + 1'b1;
    end
  end

  assign state_o = state_q;
  assign beat_o  = beat_q;
endmodule

// File: rtl/qbs_lane.sv
module qbs_lane #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  localparam int BEAT_W = $clog2(LANES),
  localparam int WIDE_W = LANES * WORD_W,
  localparam int BYTE_SH = $clog2(WORD_W / 8)
) (
  input  logic [ADDR_W-1:0] ea_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic [WIDE_W-1:0] src_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] wdata_o
);
  logic [WORD_W-1:0] lane_w [LANES];

  // lane k occupies the k-th word from the bottom
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_w[k] = src_i[k*WORD_W +: WORD_W];
  end

  assign addr_o  = ea_i + (ADDR_W'(beat_i) << BYTE_SH);
  assign wdata_o = lane_w[beat_i];
endmodule

// File: rtl/qw_beat_seq.sv
module qw_beat_seq
  import qbs_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5,
  localparam int BEAT_W = $clog2(LANES),
  localparam int WIDE_W = LANES * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WIDE_W-1:0] src_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              retire_o,
  output logic              wide_we_o,
  output logic [IDX_W-1:0]  wide_idx_o,
  output logic [BEAT_W-1:0] wide_lane_o,
  output logic [WORD_W-1:0] wide_data_o,
  output logic              scalar_we_o,
  output logic [WORD_W-1:0] scalar_data_o
);
  localparam logic [BEAT_W-1:0] LAST_QUAD = BEAT_W'(LANES - 1);
  localparam logic [BEAT_W-1:0] LAST_DBL  = BEAT_W'(LANES / 2 - 1);

  op_e               op_q;
  logic [ADDR_W-1:0] ea_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WIDE_W-1:0] src_q;
  logic [WORD_W-1:0] lane0_q;

  state_e            state;
  logic [BEAT_W-1:0] beat;
  logic              accept, beat_done, final_beat, op_ok, is_load, wr_ok;
  logic [BEAT_W-1:0] last_beat;

  assign op_ok     = (op_i != OP_BAD);
  assign last_beat = (op_q == OP_SD) ? LAST_DBL : LAST_QUAD;
  assign is_load   = (op_q == OP_LQ);
  assign wr_ok     = is_load && (idx_q != '0);

  qbs_ctrl #(.BEAT_W(BEAT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .op_ok_i     (op_ok),
    .last_beat_i (last_beat),
    .mem_ready_i (mem_ready_i),
    .state_o     (state),
    .beat_o      (beat),
    .accept_o    (accept),
    .beat_done_o (beat_done),
    .final_o     (final_beat)
  );

  qbs_lane #(.LANES(LANES), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_lane (
    .ea_i    (ea_q),
    .beat_i  (beat),
    .src_i   (src_q),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_LQ;
      ea_q    <= '0;
      idx_q   <= '0;
      src_q   <= '0;
      lane0_q <= '0;
    end else begin
      if (accept) begin
        op_q  <= op_e'(op_i);
        ea_q  <= ea_i;
        idx_q <= idx_i;
        src_q <= src_i;
      end
      if (beat_done && beat == '0) lane0_q <= mem_rdata_i;
    end
  end

  assign mem_req_o     = (state == ST_REQ);
  assign mem_we_o      = (state != ST_IDLE) && !is_load;
  assign busy_o        = (state != ST_IDLE);
  assign retire_o      = final_beat;
  assign wide_we_o     = beat_done && wr_ok;
  assign wide_idx_o    = idx_q;
  assign wide_lane_o   = beat;
  assign wide_data_o   = mem_rdata_i;
  assign scalar_we_o   = final_beat && wr_ok;
  // a one-beat config would finish before lane 0 is registered
  assign scalar_data_o = (beat == '0) ? mem_rdata_i : lane0_q;
endmodule

// File: rtl/qw_beat_seq_chk.sv
module qw_beat_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mem_req_o,
  input logic       busy_o,
  input logic       retire_o,
  input logic       wide_we_o,
  input logic [4:0] wide_idx_o,
  input logic       scalar_we_o
);
  // R3
  req_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  // R2
  req_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  // R7
  retire_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |=> !busy_o);
  // R7
  retire_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |-> busy_o && !mem_req_o);
  // R10
  zero_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide_we_o |-> wide_idx_o != 5'd0);
  // R6
  scalar_final_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scalar_we_o |-> retire_o && wide_we_o);
endmodule

bind qw_beat_seq qw_beat_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .busy_o      (busy_o),
  .retire_o    (retire_o),
  .wide_we_o   (wide_we_o),
  .wide_idx_o  (wide_idx_o),
  .scalar_we_o (scalar_we_o)
);

// File: tb/qw_beat_seq_tb_top.sv
module qw_beat_seq_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic         start_i = 1'b0;
  logic [1:0]   op_i = 2'd0;
  logic [31:0]  ea_i = '0;
  logic [4:0]   idx_i = '0;
  logic [127:0] src_i = '0;
  logic         mem_ready_i = 1'b0;
  logic [31:0]  mem_rdata_i = '0;
  logic         mem_req_o, mem_we_o, busy_o, retire_o, wide_we_o, scalar_we_o;
  logic [31:0]  mem_addr_o, mem_wdata_o, wide_data_o, scalar_data_o;
  logic [4:0]   wide_idx_o;
  logic [1:0]   wide_lane_o;

  qw_beat_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i), .ea_i(ea_i),
    .idx_i(idx_i), .src_i(src_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i),
    .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .retire_o(retire_o),
    .wide_we_o(wide_we_o), .wide_idx_o(wide_idx_o), .wide_lane_o(wide_lane_o),
    .wide_data_o(wide_data_o), .scalar_we_o(scalar_we_o), .scalar_data_o(scalar_data_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  typedef struct packed {
    logic [1:0]   op;
    logic [31:0]  ea;
    logic [4:0]   idx;
    logic [127:0] src;
    logic [2:0]   lat;
    logic         early;
    logic         poke;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{2'd0, 32'h0000_1000, 5'd4,  128'h0, 3'd0, 1'b0, 1'b0},
    '{2'd0, 32'h8000_0FF0, 5'd31, 128'h0, 3'd3, 1'b1, 1'b0},
    '{2'd1, 32'h0000_2000, 5'd9,
      128'h4444_4444_3333_3333_2222_2222_1111_1111, 3'd0, 1'b0, 1'b0},
    '{2'd1, 32'hFFFF_FFF0, 5'd1,
      128'hDEAD_BEEF_0BAD_F00D_CAFE_BABE_1234_5678, 3'd2, 1'b1, 1'b0},
    '{2'd2, 32'h0000_3008, 5'd2,
      128'hAAAA_AAAA_BBBB_BBBB_0F0F_0F0F_F0F0_F0F0, 3'd1, 1'b0, 1'b0},
    '{2'd2, 32'h0010_0000, 5'd0,
      128'h9999_9999_8888_8888_7777_7777_6666_6666, 3'd4, 1'b0, 1'b0},
    '{2'd0, 32'h0000_4000, 5'd0,  128'h0, 3'd1, 1'b0, 1'b0},
    '{2'd0, 32'h0000_5010, 5'd7,  128'h0, 3'd2, 1'b0, 1'b1}
  };

  // Runs one instruction at the ports and checks every beat against the requirements.
  task automatic run_op(input vec_t v);
    int beats = 0, wlat = -1, retires = 0, cyc = 0, wides = 0, scal = 0;
    int nexp;
    bit load;
    logic [31:0] cur_addr = '0;
    load = (v.op == 2'd0);
    nexp = (v.op == 2'd2) ? 2 : 4;
    @(negedge clk);
    start_i = 1'b1; op_i = v.op; ea_i = v.ea; idx_i = v.idx; src_i = v.src;
    @(negedge clk);
    if (v.poke) begin
      op_i = 2'd1; ea_i = 32'hBAD0_0000;
    end else start_i = 1'b0;
    check(busy_o === 1'b1, "R2", "busy after start", {31'b0, busy_o}, 32'd1);
    while (retires == 0 && cyc < 200) begin
      mem_ready_i = 1'b0;
      #1;
      if (mem_req_o) begin
        check(mem_addr_o === v.ea + 32'(4 * beats), "R4", "beat address", mem_addr_o,
              v.ea + 32'(4 * beats));
        check(mem_we_o === !load, "R8", "write flag", {31'b0, mem_we_o}, {31'b0, !load});
        if (!load)
          check(mem_wdata_o === v.src[32*beats +: 32], (v.op == 2'd2) ? "R9" : "R11",
                "store lane data", mem_wdata_o, v.src[32*beats +: 32]);
        cur_addr = mem_addr_o;
        wlat = int'(v.lat);
        beats++;
        if (v.early) begin
          mem_ready_i = 1'b1; mem_rdata_i = 32'hFFFF_0000;
        end
      end else if (wlat == 0) begin
        check(mem_req_o === 1'b0, "R3", "no request while waiting", {31'b0, mem_req_o}, 0);
        mem_ready_i = 1'b1;
        mem_rdata_i = mem_word(cur_addr);
        #1;
        if (wide_we_o) begin
          wides++;
          check(wide_lane_o === 2'(beats - 1) && wide_idx_o === v.idx &&
                wide_data_o === mem_word(cur_addr), "R5", "lane write",
                {25'b0, wide_idx_o, wide_lane_o}, {25'b0, v.idx, 2'(beats - 1)});
        end
        if (scalar_we_o) begin
          scal++;
          check(scalar_data_o === mem_word(v.ea), "R6", "scalar data", scalar_data_o,
                mem_word(v.ea));
        end
        if (retire_o) begin
          retires++;
          start_i = 1'b0;
        end
        wlat = -1;
      end else if (wlat > 0) wlat--;
      @(negedge clk);
      cyc++;
    end
    mem_ready_i = 1'b0;
    start_i = 1'b0;
    check(retires == 1, "R7", "single retire", 32'(retires), 1);
    check(beats == nexp, (v.op == 2'd2) ? "R9" : "R8", "beat count", 32'(beats), 32'(nexp));
    if (load && v.idx != 0) begin
      check(wides == 4, "R5", "lane writes", 32'(wides), 4);
      check(scal == 1, "R6", "scalar writes", 32'(scal), 1);
    end else begin
      check(wides == 0, "R10", "no lane writes", 32'(wides), 0);
      check(scal == 0, "R10", "no scalar write", 32'(scal), 0);
    end
    #1;
    check(busy_o === 1'b0, "R7", "idle after retire", {31'b0, busy_o}, 0);
    @(negedge clk);
    #1;
    check(busy_o === 1'b0 && mem_req_o === 1'b0, "R2", "no restart after poke",
          {31'b0, busy_o}, 0);
  endtask

  bit done = 1'b0;
  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    check(busy_o === 1'b0 && mem_req_o === 1'b0 && retire_o === 1'b0 &&
          wide_we_o === 1'b0 && scalar_we_o === 1'b0, "R1", "reset outputs",
          {27'b0, busy_o, mem_req_o, retire_o, wide_we_o, scalar_we_o}, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) run_op(VECS[i]);
    // invalid opcode is ignored
    @(negedge clk);
    start_i = 1'b1; op_i = 2'd3; ea_i = 32'h100;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) begin
      #1;
      check(busy_o === 1'b0 && mem_req_o === 1'b0, "R2", "bad op ignored",
            {31'b0, busy_o}, 0);
      @(negedge clk);
    end
    // ready while idle has no effect
    mem_ready_i = 1'b1;
    #1;
    check(retire_o === 1'b0 && wide_we_o === 1'b0, "R3", "idle ready ignored",
          {31'b0, retire_o}, 0);
    @(negedge clk);
    mem_ready_i = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule